// File: doc/BRIEF.md
# No-turnaround synchronous SRAM core

This block is a cycle-accurate, synthesizable model of a synchronous static RAM with late write. Reads and writes can follow each other on consecutive clock edges with no idle cycle between them. Address, commands, byte strobes and write data are all sampled on the rising clock edge. Write data is due one enabled edge after its command in flow-through timing, or two enabled edges after it in pipelined timing. Read data leaves either straight from the array after the capturing edge, or through one more output register. A static pin picks the timing.

A command is either a load or a continuation. A load names a fresh address and starts a read, a write or a deselect. A continuation repeats the last loaded operation at the next address of a four-word group. The order within the group is linear or interleaved. The array is built from 9-bit lanes with one write strobe per lane. When a read follows a write to the same word before that write has reached the array, the read returns the merged data of the pending write. The output is a data bus plus a drive flag.

Top module: `nbt_sram_core`

## Requirements
- R1: While and after reset, with no read issued, `rd_drive` is 0 and `rd_data` is all zeros.
- R2: With `pipe_en`=0 (flow-through), a read captured at edge k drives its word between edge k and edge k+1. Write data is taken at the next enabled edge after the write command.
- R3: With `pipe_en`=1 (pipelined), a read captured at edge k drives its word between edge k+1 and edge k+2. Write data is taken two enabled edges after the write command.
- R4: Reads and writes can be issued on every consecutive enabled edge, in any mix. Each read returns the content left by all writes issued before it.
- R5: A read issued while a write to the same word is still waiting for its data returns that write's data in the strobed lanes and the older content in the other lanes.
- R6: Lane i is bits [9i+8:9i]. A write changes lane i only when `lane_wr_n[i]` is 0 in the command cycle. Lanes whose strobe is 1 keep their content.
- R7: `burst_next`=0 loads `addr` as a new command. `burst_next`=1 repeats the last loaded operation (read, write or deselect) at the next burst position, keeping address bits above bit 1.
- R8: For burst step n=0..3 from start offset s = addr[1:0], the offset is (s+n) mod 4 when `order_il`=0 and s XOR n when `order_il`=1.
- R9: A load is a valid access only when `cs_a_n`=0, `cs_b`=1 and `cs_c_n`=0. Otherwise it is a deselect, and `rd_drive` stays 0 in the slot where its read data would have appeared.
- R10: While `clk_en_n`=1 every internal state, the array included, holds. The output bus keeps its value, and commands and data presented meanwhile are ignored.
- R11: `oe_n`=1 forces `rd_drive` to 0 and `rd_data` to zero at once, without waiting for a clock edge.
- R12: `sleep`=1 forces `rd_drive` low at once. Edges during sleep are ignored and the array content is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes all state |
| pipe_en | input | 1 | 1 = pipelined timing, 0 = flow-through timing (static) |
| order_il | input | 1 | 1 = interleaved burst order, 0 = linear (static) |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| cs_c_n | input | 1 | Chip select, active low |
| burst_next | input | 1 | 0 = load new command, 1 = continue burst |
| wr_n | input | 1 | Active-low write command on a load |
| lane_wr_n | input | LANES | Active-low write strobe per 9-bit lane |
| addr | input | AW | Word address |
| wr_data | input | 9*LANES | Late write data |
| oe_n | input | 1 | Asynchronous active-low output enable |
| sleep | input | 1 | Asynchronous active-high sleep |
| rd_data | output | 9*LANES | Read data, zero when not driving |
| rd_drive | output | 1 | High when the core drives `rd_data` |

## Verification
A wrong pipeline stage shows up as read data one slot early or late, or as `rd_drive` asserted in a deselect slot. In flow-through timing this is visible in the cycle right after the capturing edge, and one cycle later in pipelined timing. A faulty burst counter or order select returns a neighbouring word of the same group within four cycles. A missing write forward or lane merge shows up on the read issued right after a write to the same word. A clock-enable or sleep leak shows later, as a changed word on a read issued after the freeze ends.

// File: rtl/nbt_pkg.sv
`timescale 1ns/1ps
package nbt_pkg;

  localparam int unsigned LANE_W = 9;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // position inside a four-word burst group
  function automatic logic [1:0] burst_offset(input logic [1:0] start,
                                              input logic [1:0] step_n,
                                              input logic       interleave);
    return interleave ? (start ^ step_n) : (start + step_n);
  endfunction

endpackage

// File: rtl/nbt_burst_gen.sv
`timescale 1ns/1ps
module nbt_burst_gen
  import nbt_pkg::*;
#(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             burst_next,
  input  logic             sel_ok,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [AW-1:0]    addr,
  input  logic             order_il,
  output op_e              op_o,
  output logic [AW-1:0]    addr_o,
  output logic [LANES-1:0] be_o
);

  op_e           last_op_q, op_n;
  logic [AW-1:0] base_q, base_n;
  logic [1:0]    cnt_q, cnt_n;

  always_comb begin
    if (!burst_next) begin
      cnt_n  = 2'd0;
      base_n = addr;
      addr_o = addr;
      if (!sel_ok)    op_n = OP_NONE;
      else if (wr_n)  op_n = OP_READ;
      else            op_n = OP_WRITE;
    end else begin
      cnt_n  = cnt_q + 2'd1;
      base_n = base_q;
      op_n   = last_op_q;
      addr_o = {base_q[AW-1:2], burst_offset(base_q[1:0], cnt_n, order_il)};
    end
  end

  assign op_o = op_n;
  assign be_o = (op_n == OP_WRITE) ? ~lane_wr_n : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_op_q <= OP_NONE;
      base_q    <= '0;
      cnt_q     <= 2'd0;
    end else if (step) begin
      last_op_q <= op_n;
      base_q    <= base_n;
      cnt_q     <= cnt_n;
    end
  end

  // R7
  load_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !burst_next) |=> (base_q == $past(addr)));

endmodule

// File: rtl/nbt_store.sv
`timescale 1ns/1ps
module nbt_store
  import nbt_pkg::*;
#(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 2
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [LANES-1:0]        wbe,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << AW;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wbe[l]) bank[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    assign rdata[l*LANE_W +: LANE_W] = bank[raddr];
  end

endmodule

// File: rtl/nbt_pipe.sv
`timescale 1ns/1ps
module nbt_pipe
  import nbt_pkg::*;
#(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 2,
  localparam int unsigned DW   = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             flow,
  input  logic             oe_n,
  input  logic             sleep,
  input  op_e              cmd_op,
  input  logic [AW-1:0]    cmd_addr,
  input  logic [LANES-1:0] cmd_be,
  input  logic [DW-1:0]    wr_data,
  output logic             st_we,
  output logic [AW-1:0]    st_waddr,
  output logic [LANES-1:0] st_wbe,
  output logic [DW-1:0]    st_wdata,
  output logic [AW-1:0]    st_raddr,
  input  logic [DW-1:0]    st_rdata,
  output logic [DW-1:0]    rd_data,
  output logic             rd_drive
);

  op_e              s1_op_q, s1_op_n, s2_op_q, s2_op_n;
  logic [AW-1:0]    s1_addr_q, s1_addr_n, s2_addr_q, s2_addr_n;
  logic [LANES-1:0] s1_be_q, s1_be_n, s2_be_q, s2_be_n;
  logic [DW-1:0]    q_data, q_data_n, fwd_data;
  logic             q_drv, q_drv_n;
  logic             hit, out_drv;

  // late-write commit point: stage 1 in flow-through, stage 2 in pipelined
  assign st_we    = step && (flow ? (s1_op_q == OP_WRITE) : (s2_op_q == OP_WRITE));
  assign st_waddr = flow ? s1_addr_q : s2_addr_q;
  assign st_wbe   = flow ? s1_be_q : s2_be_q;
  assign st_wdata = wr_data;
  assign st_raddr = s1_addr_q;

  // a write committing on the same edge the output register samples
  assign hit = !flow && (s2_op_q == OP_WRITE) && (s2_addr_q == s1_addr_q);

  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign fwd_data[l*LANE_W +: LANE_W] = (hit && s2_be_q[l]) ?
      wr_data[l*LANE_W +: LANE_W] : st_rdata[l*LANE_W +: LANE_W];
  end

  always_comb begin
    s1_op_n   = s1_op_q;   s1_addr_n = s1_addr_q; s1_be_n = s1_be_q;
    s2_op_n   = s2_op_q;   s2_addr_n = s2_addr_q; s2_be_n = s2_be_q;
    q_data_n  = q_data;    q_drv_n   = q_drv;
    if (step) begin
      s1_op_n   = cmd_op;   s1_addr_n = cmd_addr;  s1_be_n = cmd_be;
      s2_op_n   = s1_op_q;  s2_addr_n = s1_addr_q; s2_be_n = s1_be_q;
      q_data_n  = fwd_data;
      q_drv_n   = (s1_op_q == OP_READ);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op_q <= OP_NONE; s1_addr_q <= '0; s1_be_q <= '0;
      s2_op_q <= OP_NONE; s2_addr_q <= '0; s2_be_q <= '0;
      q_data  <= '0;      q_drv     <= 1'b0;
    end else begin
      s1_op_q <= s1_op_n; s1_addr_q <= s1_addr_n; s1_be_q <= s1_be_n;
      s2_op_q <= s2_op_n; s2_addr_q <= s2_addr_n; s2_be_q <= s2_be_n;
      q_data  <= q_data_n; q_drv    <= q_drv_n;
    end
  end

  assign out_drv  = flow ? (s1_op_q == OP_READ) : q_drv;
  assign rd_drive = out_drv && !oe_n && !sleep;
  assign rd_data  = rd_drive ? (flow ? st_rdata : q_data) : '0;

  // R10
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(q_data) && $stable(s1_op_q) && $stable(s2_op_q)));

  // R3
  pipe_read_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !flow && s1_op_q == OP_READ) |=> q_drv);

  // R11
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!rd_drive && rd_data == '0));

  // R12
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!rd_drive && !st_we));

  // R2
  flow_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flow && step && s1_op_q == OP_WRITE) |-> st_we);

endmodule

// File: rtl/nbt_sram_core.sv
`timescale 1ns/1ps
module nbt_sram_core
  import nbt_pkg::*;
#(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 2,
  localparam int unsigned DW   = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_n,
  input  logic             pipe_en,
  input  logic             order_il,
  input  logic             cs_a_n,
  input  logic             cs_b,
  input  logic             cs_c_n,
  input  logic             burst_next,
  input  logic             wr_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wr_data,
  input  logic             oe_n,
  input  logic             sleep,
  output logic [DW-1:0]    rd_data,
  output logic             rd_drive
);

  logic             step, sel_ok, flow;
  op_e              cmd_op;
  logic [AW-1:0]    cmd_addr;
  logic [LANES-1:0] cmd_be;
  logic             st_we;
  logic [AW-1:0]    st_waddr, st_raddr;
  logic [LANES-1:0] st_wbe;
  logic [DW-1:0]    st_wdata, st_rdata;

  assign step   = !clk_en_n && !sleep;
  assign sel_ok = !cs_a_n && cs_b && !cs_c_n;
  assign flow   = !pipe_en;

  nbt_burst_gen #(.AW(AW), .LANES(LANES)) u_burst (
    .clk(clk), .rst_n(rst_n), .step(step), .burst_next(burst_next),
    .sel_ok(sel_ok), .wr_n(wr_n), .lane_wr_n(lane_wr_n), .addr(addr),
    .order_il(order_il), .op_o(cmd_op), .addr_o(cmd_addr), .be_o(cmd_be)
  );

  nbt_pipe #(.AW(AW), .LANES(LANES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .step(step), .flow(flow), .oe_n(oe_n),
    .sleep(sleep), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_be(cmd_be),
    .wr_data(wr_data), .st_we(st_we), .st_waddr(st_waddr), .st_wbe(st_wbe),
    .st_wdata(st_wdata), .st_raddr(st_raddr), .st_rdata(st_rdata),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  nbt_store #(.AW(AW), .LANES(LANES)) u_store (
    .clk(clk), .we(st_we), .waddr(st_waddr), .wbe(st_wbe),
    .wdata(st_wdata), .raddr(st_raddr), .rdata(st_rdata)
  );

  // R9
  desel_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !burst_next && !sel_ok && !pipe_en) |=> !rd_drive);

endmodule

// File: tb/sim_nbt_sram_core.sv
`timescale 1ns/1ps
module sim_nbt_sram_core;

  localparam int AW = 6;
  localparam int LANES = 2;
  localparam int DW = 18;

  typedef struct {
    int             due;
    logic [DW-1:0]  data;
    string          tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic clk_en_n, pipe_en, order_il, cs_a_n, cs_b, cs_c_n, burst_next, wr_n;
  logic [LANES-1:0] lane_wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wr_data;
  logic oe_n, sleep;
  logic [DW-1:0] rd_data;
  logic rd_drive;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit mon_en = 1'b0;
  bit finished = 1'b0;
  exp_t sbq[$];

  logic [DW-1:0] mem_m [64];
  logic [DW-1:0] wd_slot [4];
  int            m_op = 0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = 2'd0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nbt_sram_core #(.AW(AW), .LANES(LANES)) u0 (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .pipe_en(pipe_en),
    .order_il(order_il), .cs_a_n(cs_a_n), .cs_b(cs_b), .cs_c_n(cs_c_n),
    .burst_next(burst_next), .wr_n(wr_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .wr_data(wr_data), .oe_n(oe_n), .sleep(sleep),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp_v);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // kind: 0 deselect load, 1 read load, 2 write load, 3 burst continue
  task automatic cmd(input int kind, input logic [AW-1:0] a,
                     input logic [1:0] bwn, input logic [DW-1:0] d,
                     input int pin, input string tag);
    int cn, lat;
    logic [1:0] off;
    logic [AW-1:0] ea;
    @(negedge clk);
    cn  = cyc + 1;
    lat = pipe_en ? 2 : 1;
    wr_data = wd_slot[cn % 4];
    cs_a_n = 1'b0; cs_b = 1'b1; cs_c_n = 1'b0;
    burst_next = (kind == 3);
    wr_n = (kind != 2);
    lane_wr_n = bwn;
    addr = a;
    ea = a;
    if (kind == 0) begin
      m_op = 0;
      if (pin == 1) cs_a_n = 1'b1;
      else if (pin == 2) cs_b = 1'b0;
      else cs_c_n = 1'b1;
    end else if (kind == 3) begin
      m_cnt = m_cnt + 2'd1;
      off = order_il ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
      ea = {m_base[AW-1:2], off};
    end else begin
      m_op = kind; m_base = a; m_cnt = 2'd0;
    end
    if (kind == 0 || (kind == 3 && m_op == 0)) begin
      // nothing expected
    end else if (m_op == 1) begin
      if (mon_en) sbq.push_back('{cn + (pipe_en ? 1 : 0), mem_m[ea], tag});
    end else begin
      for (int l = 0; l < LANES; l++)
        if (!bwn[l]) mem_m[ea][l*9 +: 9] = d[l*9 +: 9];
      wd_slot[(cn + lat) % 4] = d;
    end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cmd(0, '0, 2'b11, '0, 1, "R9");
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (mon_en) begin
      if (sbq.size() > 0 && sbq[0].due == cyc) begin
        exp_t it;
        it = sbq.pop_front();
        chk(rd_drive === 1'b1 && rd_data === it.data, it.tag, rd_data, it.data);
      end else begin
        // R9 no drive outside read slots
        chk(rd_drive === 1'b0, "R9", {17'd0, rd_drive}, '0);
      end
    end
  end

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 1'b0; clk_en_n = 1'b0; pipe_en = 1'b0; order_il = 1'b0;
    cs_a_n = 1'b1; cs_b = 1'b1; cs_c_n = 1'b0; burst_next = 1'b0; wr_n = 1'b1;
    lane_wr_n = 2'b11; addr = '0; wr_data = '0; oe_n = 1'b0; sleep = 1'b0;
    for (int i = 0; i < 4; i++) wd_slot[i] = '0;
    for (int i = 0; i < 64; i++) mem_m[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(rd_drive === 1'b0 && rd_data === '0, "R1", rd_data, '0);
    mon_en = 1'b1;

    // flow-through, linear
    for (int i = 8; i < 12; i++) cmd(2, i[AW-1:0], 2'b00, 18'h1000 + i * 18'h111, 1, "R2");
    cmd(1, 6'd8, 2'b11, '0, 1, "R2");
    cmd(2, 6'd12, 2'b00, 18'h2_5A5A, 1, "R4");
    cmd(1, 6'd9, 2'b11, '0, 1, "R4");
    cmd(2, 6'd13, 2'b00, 18'h0_F0F1, 1, "R4");
    cmd(1, 6'd12, 2'b11, '0, 1, "R4");
    cmd(1, 6'd13, 2'b11, '0, 1, "R4");
    cmd(2, 6'd8, 2'b10, 18'h3_ABCD, 1, "R6");
    cmd(1, 6'd8, 2'b11, '0, 1, "R6");
    cmd(2, 6'd10, 2'b01, 18'h1_2345, 1, "R6");
    cmd(1, 6'd10, 2'b11, '0, 1, "R6");
    idle(2);
    // linear bursts
    cmd(2, 6'd21, 2'b00, 18'h0_0A01, 1, "R7");
    cmd(3, '0, 2'b00, 18'h0_0A02, 1, "R7");
    cmd(3, '0, 2'b00, 18'h0_0A03, 1, "R7");
    cmd(3, '0, 2'b00, 18'h0_0A04, 1, "R7");
    cmd(1, 6'd22, 2'b11, '0, 1, "R8");
    for (int i = 0; i < 3; i++) cmd(3, '0, 2'b11, '0, 1, "R8");
    cmd(0, 6'd20, 2'b11, '0, 2, "R9");
    cmd(3, '0, 2'b11, '0, 1, "R7");
    cmd(0, 6'd20, 2'b11, '0, 3, "R9");
    cmd(1, 6'd23, 2'b11, '0, 1, "R7");
    idle(3);

    // pipelined, interleaved
    pipe_en = 1'b1; order_il = 1'b1;
    idle(2);
    for (int i = 32; i < 36; i++) cmd(2, i[AW-1:0], 2'b00, 18'h2000 + i * 18'h203, 1, "R3");
    cmd(1, 6'd33, 2'b11, '0, 1, "R3");
    cmd(2, 6'd36, 2'b00, 18'h1_1111, 1, "R4");
    cmd(1, 6'd32, 2'b11, '0, 1, "R4");
    cmd(1, 6'd36, 2'b11, '0, 1, "R5");
    cmd(2, 6'd40, 2'b00, 18'h2_2222, 1, "R5");
    cmd(1, 6'd40, 2'b11, '0, 1, "R5");
    cmd(2, 6'd40, 2'b01, 18'h0_7777, 1, "R5");
    cmd(1, 6'd40, 2'b11, '0, 1, "R5");
    cmd(0, '0, 2'b11, '0, 3, "R9");
    cmd(1, 6'd35, 2'b11, '0, 1, "R3");
    cmd(2, 6'd42, 2'b00, 18'h0_0B01, 1, "R8");
    for (int i = 0; i < 3; i++) cmd(3, '0, 2'b00, 18'h0_0B02 + i, 1, "R8");
    cmd(1, 6'd41, 2'b11, '0, 1, "R8");
    for (int i = 0; i < 3; i++) cmd(3, '0, 2'b11, '0, 1, "R8");
    idle(4);
    mon_en = 1'b0;
    chk(sbq.size() == 0, "R3", 18'(sbq.size()), '0);

    // directed freeze, output enable and sleep, flow-through
    pipe_en = 1'b0;
    idle(2);
    cmd(1, 6'd9, 2'b11, '0, 1, "R2");
    @(negedge clk);
    chk(rd_drive === 1'b1 && rd_data === mem_m[9], "R2", rd_data, mem_m[9]);
    clk_en_n = 1'b1; burst_next = 1'b0; cs_a_n = 1'b0; cs_b = 1'b1; cs_c_n = 1'b0;
    wr_n = 1'b0; lane_wr_n = 2'b00; addr = 6'd10; wr_data = 18'h3_FFFF;
    @(negedge clk);
    chk(rd_drive === 1'b1 && rd_data === mem_m[9], "R10", rd_data, mem_m[9]);
    @(negedge clk);
    chk(rd_drive === 1'b1 && rd_data === mem_m[9], "R10", rd_data, mem_m[9]);
    oe_n = 1'b1; #1;
    chk(rd_drive === 1'b0 && rd_data === '0, "R11", rd_data, '0);
    oe_n = 1'b0; #1;
    chk(rd_drive === 1'b1 && rd_data === mem_m[9], "R11", rd_data, mem_m[9]);
    sleep = 1'b1; #1;
    chk(rd_drive === 1'b0, "R12", {17'd0, rd_drive}, '0);
    clk_en_n = 1'b0; addr = 6'd9; wr_data = 18'h3_0000;
    @(negedge clk);
    @(negedge clk);
    chk(rd_drive === 1'b0, "R12", {17'd0, rd_drive}, '0);
    sleep = 1'b0; cs_a_n = 1'b1; wr_n = 1'b1; lane_wr_n = 2'b11;
    cmd(1, 6'd9, 2'b11, '0, 1, "R12");
    @(negedge clk);
    chk(rd_drive === 1'b1 && rd_data === mem_m[9], "R12", rd_data, mem_m[9]);
    cmd(1, 6'd10, 2'b11, '0, 1, "R10");
    @(negedge clk);
    chk(rd_drive === 1'b1 && rd_data === mem_m[10], "R10", rd_data, mem_m[10]);
    summary();
  end

endmodule